// File: doc/BRIEF.md
# CRT Scan Timing Generator with Retrace Status

This block produces the raster timing of a character-based CRT controller. A dot-clock enable advances a dot counter that forms character cells. The cells form scan lines, and the scan lines form frames. A small host register file holds the programmable totals: a horizontal total, a vertical total with two extension bits in an overflow register, a clocking-mode register and a miscellaneous-output register. From these it derives the cell width, the line length and the frame length.

A host reading the status address sees the current retrace condition. That same read sends a one-cycle pulse to the attribute controller, which returns its address/data toggle to the address state. The clock-select field of the miscellaneous-output register is passed straight out to the clock generator. New totals take effect only when the matching counter wraps, so a line or frame in progress always finishes at its old length.

Top module: `crt_scan_timer`

## Requirements
- R1: With clocking-mode bit 3 clear, a scan line holds (horizontal total + 5) character cells, numbered 0 upward on `cellIdx`.
- R2: With clocking-mode bit 3 set, the number of cells per line is doubled, to 2 × (horizontal total + 5).
- R3: A character cell lasts 8 dot-enable pulses when clocking-mode bit 0 is 1, and 9 when it is 0.
- R4: A frame holds vertical total + 256 × overflow bit 0 + 512 × overflow bit 5 + 2 scan lines, numbered 0 upward on `lineIdx`.
- R5: `clkSel` equals bits 3:2 of the miscellaneous-output register. Code 1 means the faster dot clock.
- R6: `hRetrace` is high during the last cell of each line, and `vRetrace` is high during lines 0 and 1. In the status byte, bit 3 is vertical retrace, bit 0 is horizontal or vertical retrace, and all other bits are 0.
- R7: Every read of the status address drives `flipClear` high for exactly the cycle after the read.
- R8: A new horizontal value (total, cell width or halving) takes effect at the next line wrap. A new vertical value takes effect at the next frame wrap.
- R9: Host map: 0 horizontal total, 1 vertical total, 2 overflow, 3 vertical display end, 4 clocking mode, 5 miscellaneous output, 6 status (read-only). Read data appears on `rdData` one cycle after `rdEn` and holds until the next read. Addresses 0 to 5 read back their stored values. Address 7 reads 0, and writes to addresses 6 and 7 change nothing.
- R10: Synchronous active-high reset clears all registers and counters. This leaves 5 cells of 9 dots per line and 2 lines per frame.
- R11: Counters advance only in cycles in which `dotEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dotEn | input | 1 | Dot-clock enable, one dot per high cycle |
| hostAddr | input | 3 | Host register address |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write data |
| rdEn | input | 1 | Host read strobe |
| rdData | output | 8 | Registered host read data |
| flipClear | output | 1 | Pulse that resets the attribute address/data toggle |
| clkSel | output | 2 | Dot-clock source select |
| hRetrace | output | 1 | Horizontal retrace active |
| vRetrace | output | 1 | Vertical retrace active |
| cellIdx | output | 10 | Current cell within the line |
| lineIdx | output | 11 | Current scan line within the frame |

## Verification
The hardest case to reach is a frame that uses both vertical extension bits. That frame is 771 lines long, and its total is held pending until the previous frame ends. The stimulus sets 8-dot cells and a minimum horizontal total to keep lines short. It then runs a whole extended frame with a gapped dot enable and reads status throughout, so retrace is seen at both frame wraps. Totals are also rewritten in the middle of lines and frames, to confirm that the old length completes before the new one is used.

// File: rtl/crt_timer_pkg.sv
package crt_timer_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_HTOT    = 3'd0,
    A_VTOT    = 3'd1,
    A_OVFL    = 3'd2,
    A_VDEND   = 3'd3,
    A_CLKMODE = 3'd4,
    A_MISC    = 3'd5,
    A_STATUS  = 3'd6,
    A_SPARE   = 3'd7
  } hostAddrE;

  typedef struct packed {
    logic cellAdv;   // last dot of a cell
    logic lineAdv;   // last dot of the last cell of a line
    logic frameAdv;  // last dot of the last line of a frame
  } scanStrobeT;
endpackage

// File: rtl/crt_host_regs.sv
module crt_host_regs
  import crt_timer_pkg::*;
#(
  parameter int CELL_W   = 10,
  parameter int LINE_W   = 11,
  parameter int DOT_W    = 4,
  parameter int HTOT_ADD = 5,
  parameter int VTOT_ADD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic              hRetrace,
  input  logic              vRetrace,
  output logic [REG_W-1:0]  rdData,
  output logic              flipClear,
  output logic [1:0]        clkSel,
  output logic [CELL_W-1:0] nextCells,
  output logic [DOT_W-1:0]  nextDots,
  output logic [LINE_W-1:0] nextLines
);
  logic [REG_W-1:0] hTotReg, vTotReg, ovflReg, vDendReg, clkModeReg, miscReg;
  logic [REG_W-1:0] statusByte;
  logic [REG_W-1:0] readMux;
  logic [CELL_W-1:0] baseCells;

  always_ff @(posedge clk) begin
    if (rst) begin
      hTotReg    <= '0;
      vTotReg    <= '0;
      ovflReg    <= '0;
      vDendReg   <= '0;
      clkModeReg <= '0;
      miscReg    <= '0;
    end else if (wrEn) begin
      case (hostAddrE'(hostAddr))
        A_HTOT:    hTotReg    <= wrData;
        A_VTOT:    vTotReg    <= wrData;
        A_OVFL:    ovflReg    <= wrData;
        A_VDEND:   vDendReg   <= wrData;
        A_CLKMODE: clkModeReg <= wrData;
        A_MISC:    miscReg    <= wrData;
        default:   ;
      endcase
    end
  end

  // Derived totals follow every register write; the datapath picks them up at its wraps.
  always_comb begin
    baseCells = CELL_W'(hTotReg) + CELL_W'(HTOT_ADD);
    nextCells = clkModeReg[3] ? (baseCells << 1) : baseCells;
    nextDots  = clkModeReg[0] ? DOT_W'(8) : DOT_W'(9);
    nextLines = LINE_W'(vTotReg)
              + (LINE_W'(ovflReg[0]) << 8)
              + (LINE_W'(ovflReg[5]) << 9)
              + LINE_W'(VTOT_ADD);
  end

  assign clkSel     = miscReg[3:2];
  assign statusByte = {4'b0000, vRetrace, 2'b00, hRetrace | vRetrace};

  always_comb begin
    case (hostAddrE'(hostAddr))
      A_HTOT:    readMux = hTotReg;
      A_VTOT:    readMux = vTotReg;
      A_OVFL:    readMux = ovflReg;
      A_VDEND:   readMux = vDendReg;
      A_CLKMODE: readMux = clkModeReg;
      A_MISC:    readMux = miscReg;
      A_STATUS:  readMux = statusByte;
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData    <= '0;
      flipClear <= 1'b0;
    end else begin
      flipClear <= rdEn && (hostAddr == A_STATUS);
      if (rdEn) rdData <= readMux;
    end
  end

  AST_FLIP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (rdEn && hostAddr == A_STATUS) |=> flipClear); // R7
  AST_FLIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (flipClear && !$past(rdEn)) |-> 1'b0); // R7
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (rst)
    flipClear |-> (rdData[7:4] == 4'b0 && rdData[2:1] == 2'b0 && (!rdData[3] || rdData[0]))); // R6
  AST_CLKSEL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && hostAddr == A_MISC) |=> (clkSel == $past(wrData[3:2]))); // R5
endmodule

// File: rtl/crt_scan_ctrl.sv
module crt_scan_ctrl
  import crt_timer_pkg::*;
#(
  parameter int DOT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dotEn,
  input  logic [DOT_W-1:0] actDots,
  input  logic             cellLast,
  input  logic             lineLast,
  output scanStrobeT       strobes
);
  logic [DOT_W-1:0] dotCnt;
  logic             dotLast;

  assign dotLast          = (dotCnt == actDots - DOT_W'(1));
  assign strobes.cellAdv  = dotEn && dotLast;
  assign strobes.lineAdv  = strobes.cellAdv && cellLast;
  assign strobes.frameAdv = strobes.lineAdv && lineLast;

  always_ff @(posedge clk) begin
    if (rst)                  dotCnt <= '0;
    else if (strobes.cellAdv) dotCnt <= '0;
    else if (dotEn)           dotCnt <= dotCnt + DOT_W'(1);
  end

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    dotCnt < actDots); // R3
  AST_DOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dotEn |=> $stable(dotCnt)); // R11
endmodule

// File: rtl/crt_scan_datapath.sv
module crt_scan_datapath
  import crt_timer_pkg::*;
#(
  parameter int CELL_W   = 10,
  parameter int LINE_W   = 11,
  parameter int DOT_W    = 4,
  parameter int HTOT_ADD = 5,
  parameter int VTOT_ADD = 2,
  parameter int VRET_LINES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobeT        strobes,
  input  logic [CELL_W-1:0] nextCells,
  input  logic [DOT_W-1:0]  nextDots,
  input  logic [LINE_W-1:0] nextLines,
  output logic [CELL_W-1:0] cellIdx,
  output logic [LINE_W-1:0] lineIdx,
  output logic [DOT_W-1:0]  actDots,
  output logic              cellLast,
  output logic              lineLast,
  output logic              hRetrace,
  output logic              vRetrace
);
  logic [CELL_W-1:0] actCells;
  logic [LINE_W-1:0] actLines;

  assign cellLast = (cellIdx == actCells - CELL_W'(1));
  assign lineLast = (lineIdx == actLines - LINE_W'(1));
  assign hRetrace = cellLast;
  assign vRetrace = (lineIdx < LINE_W'(VRET_LINES));

  // Horizontal shadow: cell counter and its totals, reloaded at line wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      cellIdx  <= '0;
      actCells <= CELL_W'(HTOT_ADD);
      actDots  <= DOT_W'(9);
    end else if (strobes.lineAdv) begin
      cellIdx  <= '0;
      actCells <= nextCells;
      actDots  <= nextDots;
    end else if (strobes.cellAdv) begin
      cellIdx  <= cellIdx + CELL_W'(1);
    end
  end

  // Vertical shadow: line counter and its total, reloaded at frame wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      lineIdx  <= '0;
      actLines <= LINE_W'(VTOT_ADD);
    end else if (strobes.frameAdv) begin
      lineIdx  <= '0;
      actLines <= nextLines;
    end else if (strobes.lineAdv) begin
      lineIdx  <= lineIdx + LINE_W'(1);
    end
  end

  AST_CELL_RANGE: assert property (@(posedge clk) disable iff (rst)
    cellIdx < actCells); // R1
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    lineIdx < actLines); // R4
  AST_HTOTAL_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobes.lineAdv |=> ($stable(actCells) && $stable(actDots))); // R8
  AST_VTOTAL_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobes.frameAdv |=> $stable(actLines)); // R8
  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    strobes.frameAdv |=> (vRetrace && lineIdx == '0)); // R6
endmodule

// File: rtl/crt_scan_timer.sv
module crt_scan_timer
  import crt_timer_pkg::*;
#(
  parameter int CELL_W     = 10,
  parameter int LINE_W     = 11,
  parameter int HTOT_ADD   = 5,
  parameter int VTOT_ADD   = 2,
  parameter int VRET_LINES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dotEn,
  input  logic [2:0]        hostAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              flipClear,
  output logic [1:0]        clkSel,
  output logic              hRetrace,
  output logic              vRetrace,
  output logic [CELL_W-1:0] cellIdx,
  output logic [LINE_W-1:0] lineIdx
);
  localparam int DOT_W = 4;

  scanStrobeT        strobes;
  logic [CELL_W-1:0] nextCells;
  logic [DOT_W-1:0]  nextDots;
  logic [LINE_W-1:0] nextLines;
  logic [DOT_W-1:0]  actDots;
  logic              cellLast, lineLast;

  crt_host_regs #(
    .CELL_W(CELL_W), .LINE_W(LINE_W), .DOT_W(DOT_W),
    .HTOT_ADD(HTOT_ADD), .VTOT_ADD(VTOT_ADD)
  ) u_regs (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .hRetrace(hRetrace), .vRetrace(vRetrace), .rdData(rdData),
    .flipClear(flipClear), .clkSel(clkSel), .nextCells(nextCells),
    .nextDots(nextDots), .nextLines(nextLines)
  );

  crt_scan_ctrl #(.DOT_W(DOT_W)) u_ctrl (
    .clk(clk), .rst(rst), .dotEn(dotEn), .actDots(actDots),
    .cellLast(cellLast), .lineLast(lineLast), .strobes(strobes)
  );

  crt_scan_datapath #(
    .CELL_W(CELL_W), .LINE_W(LINE_W), .DOT_W(DOT_W),
    .HTOT_ADD(HTOT_ADD), .VTOT_ADD(VTOT_ADD), .VRET_LINES(VRET_LINES)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .nextCells(nextCells),
    .nextDots(nextDots), .nextLines(nextLines), .cellIdx(cellIdx),
    .lineIdx(lineIdx), .actDots(actDots), .cellLast(cellLast),
    .lineLast(lineLast), .hRetrace(hRetrace), .vRetrace(vRetrace)
  );
endmodule

// File: tb/crt_scan_timer_tb.sv
module crt_scan_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dotEn = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        flipClear;
  logic [1:0]  clkSel;
  logic        hRetrace, vRetrace;
  logic [9:0]  cellIdx;
  logic [10:0] lineIdx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Behavioural reference state
  int regs[8];
  int mDot, mCell, mLine, mCells, mDots, mLines, mRd, mFlip;

  always #2.5 clk = ~clk;

  crt_scan_timer u_dut (
    .clk(clk), .rst(rst), .dotEn(dotEn), .hostAddr(hostAddr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .flipClear(flipClear),
    .clkSel(clkSel), .hRetrace(hRetrace), .vRetrace(vRetrace),
    .cellIdx(cellIdx), .lineIdx(lineIdx)
  );

  function automatic int cellsPerLine();
    int c = regs[0] + 5;
    return ((regs[4] >> 3) & 1) ? 2 * c : c;
  endfunction

  function automatic int linesPerFrame();
    return regs[1] + 256 * (regs[2] & 1) + 512 * ((regs[2] >> 5) & 1) + 2;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R1 R2 R3 R8 R11 cellIdx", int'(cellIdx), mCell);
    check("R4 R8 lineIdx", int'(lineIdx), mLine);
    check("R6 hRetrace", int'(hRetrace), (mCell == mCells - 1) ? 1 : 0);
    check("R6 vRetrace", int'(vRetrace), (mLine < 2) ? 1 : 0);
    check("R5 clkSel", int'(clkSel), (regs[5] >> 2) & 3);
    check("R6 R9 rdData", int'(rdData), mRd);
    check("R7 flipClear", int'(flipClear), mFlip);
  endtask

  task automatic modelReset();
    foreach (regs[i]) regs[i] = 0;
    mDot = 0; mCell = 0; mLine = 0;
    mCells = 5; mDots = 9; mLines = 2; mRd = 0; mFlip = 0;
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic cyc(bit de, bit wr, bit rd, int addr, int data);
    int hr, vr;
    dotEn = de; wrEn = wr; rdEn = rd;
    hostAddr = 3'(addr); wrData = 8'(data);
    @(posedge clk);
    hr = (mCell == mCells - 1) ? 1 : 0;
    vr = (mLine < 2) ? 1 : 0;
    mFlip = (rd && addr == 6) ? 1 : 0;
    if (rd) begin
      if (addr == 6) mRd = (vr << 3) | (hr | vr);
      else if (addr == 7) mRd = 0;
      else mRd = regs[addr];
    end
    if (de) begin
      if (mDot == mDots - 1) begin
        mDot = 0;
        if (mCell == mCells - 1) begin
          mCell = 0;
          mCells = cellsPerLine();
          mDots = (regs[4] & 1) ? 8 : 9;
          if (mLine == mLines - 1) begin
            mLine = 0;
            mLines = linesPerFrame();
          end else mLine++;
        end else mCell++;
      end else mDot++;
    end
    if (wr && addr < 6) regs[addr] = data & 255;
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(int n, int readEvery);
    for (int i = 0; i < n; i++)
      cyc((i % 7) != 3, 1'b0, (i % readEvery) == 0, 6, 0);
  endtask

  task automatic wr(int addr, int data);
    cyc(1'b1, 1'b1, 1'b0, addr, data);
  endtask

  task automatic rd(int addr);
    cyc(1'b1, 1'b0, 1'b1, addr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state, 5 cells x 9 dots, 2 lines, all registers zero
    check("R10 cellIdx after reset", int'(cellIdx), 0);
    check("R10 lineIdx after reset", int'(lineIdx), 0);
    check("R10 vRetrace after reset", int'(vRetrace), 1);
    check("R10 hRetrace after reset", int'(hRetrace), 0);
    check("R10 rdData after reset", int'(rdData), 0);
    for (int a = 0; a < 6; a++) rd(a);
    // R11: idle dot enable keeps counters still
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b0, 0, 0);
    run(200, 5);
    // R3 R8: 8-dot cells written mid-line
    run(13, 100);
    wr(4, 8'h01);
    run(300, 4);
    // R1: horizontal total 3 gives 8 cells
    run(17, 100);
    wr(0, 3);
    rd(0);
    run(400, 3);
    // R2: halving doubles to 16 cells
    wr(4, 8'h09);
    run(700, 6);
    // R4: both extension bits, 771-line frame with short lines
    wr(4, 8'h01);
    wr(0, 0);
    wr(1, 1);
    wr(2, 8'h21);
    run(40000, 3);
    // R4 R8: only bit 0, 259 lines, written mid-frame
    wr(2, 8'h01);
    run(14000, 3);
    // R5: clock select field
    wr(5, 8'h04);
    wr(5, 8'h0C);
    wr(5, 8'hF7);
    // R9: readback, read-only status and spare address
    wr(3, 8'h55);
    rd(3);
    wr(6, 8'hFF);
    wr(7, 8'hAA);
    for (int a = 0; a < 8; a++) rd(a);
    rd(6);
    cyc(1'b1, 1'b0, 1'b0, 6, 0);
    cyc(1'b1, 1'b0, 1'b1, 6, 0);
    cyc(1'b1, 1'b0, 1'b1, 6, 0);
    run(50, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule